// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Parity

This block is a clocked static memory whose words are 72 bits wide: eight 8-bit data lanes, each carrying one parity bit of its own. Every address, data, enable, write and burst input is captured on the rising clock edge. An access starts when one of two address strobes is low. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write inputs, or deselects the memory when the bank enable is inactive.

After an access has started, a counter steps the low two address bits on every edge where the advance input is low. It holds the address on edges where that input is high. The order of the steps is chosen by a static select input: either a linear count that wraps modulo 4, or an XOR of the loaded low bits with the step number. Read data is registered and appears one clock after the edge that chose the address. An asynchronous output enable gates the read port. A snooze input freezes the whole block and keeps its contents.

Top module: `burst_parity_sram`

## Requirements
- R1: After reset no access is in progress, `q_drive` is low, and `rdata` and `rpar` are zero.
- R2: On an edge where `proc_strobe_n` and `bank_en_n` are both low, `addr` is loaded and a read begins, whatever the write inputs are. The word is on `rdata`/`rpar` one clock later. This start takes priority over the controller strobe.
- R3: On an edge where `ctrl_strobe_n` is low, `bank_en_n` is low and no processor start is present, `addr` is loaded. The access is a write if `gwrite_n` or `bwrite_en_n` is low, and a read otherwise.
- R4: On an edge where `ctrl_strobe_n` is low, `bank_en_n` is high and no processor start is present, the memory is deselected. `q_drive` is low from the next edge, and advance edges have no effect until a new start.
- R5: While an access is in progress, an edge with `advance_n` low steps the burst counter by one. Only the low two address bits change, and the upper bits keep the loaded value.
- R6: An edge with `advance_n` high and no start is a wait cycle, and the address stays the same.
- R7: With `order_sel` = 0, step k accesses low bits (loaded low bits + k) mod 4.
- R8: With `order_sel` = 1, step k accesses low bits (loaded low bits XOR k).
- R9: A write with `gwrite_n` low updates all 64 data bits and all 8 parity bits, ignoring `bwrite_en_n` and `byte_we_n`.
- R10: A write with `gwrite_n` high and `bwrite_en_n` low updates only the lanes i whose `byte_we_n[i]` is low: data bits [8i+7:8i] and parity bit i.
- R11: `out_en_n` high forces `q_drive` low and `rdata`/`rpar` to zero at once, without a clock edge and without changing any state.
- R12: While `snooze` is high, no access is accepted, `q_drive` is low, and the memory contents and the burst state are kept.
- R13: During a write access, every accepted edge (advance or wait) writes `wdata`/`wpar` at the current burst address, using the lane mask given by that edge's write inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address, loaded on a start |
| proc_strobe_n | input | 1 | Processor address strobe, starts a read |
| ctrl_strobe_n | input | 1 | Controller address strobe, starts a read, a write or a deselect |
| bank_en_n | input | 1 | Active-low bank enable |
| advance_n | input | 1 | Low steps the burst counter, high waits |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| gwrite_n | input | 1 | Active-low write of the whole word |
| bwrite_en_n | input | 1 | Active-low enable for per-lane writes |
| byte_we_n | input | LANES | Active-low per-lane write selects |
| wdata | input | LANES*LANE_W | Write data, lane i in bits [8i+7:8i] |
| wpar | input | LANES | Write parity, bit i for lane i |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| snooze | input | 1 | Active-high standby |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |
| rpar | output | LANES | Read parity, zero when not driven |
| q_drive | output | 1 | High when the read port drives valid data |

## Verification
The hardest state to reach is a write access that goes on past its first edge. A later edge writes at a stepped address with a narrower lane mask than the first one. Each beat is seen only by reading back through a separate processor-strobe burst. The stimulus opens an interleaved write at an odd address with a whole-word write, advances once with a new whole-word pattern, and then waits with a single-lane mask. Reading both addresses back shows the final lane contents at the stepped location.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/bsr_lane_mask.sv
module bsr_lane_mask #(
   parameter int LANES = 8
) (
   input  logic             gwrite_n,
   input  logic             bwrite_en_n,
   input  logic [LANES-1:0] byte_we_n,
   output logic             write_req,
   output logic [LANES-1:0] lane_mask
);
   assign write_req = !gwrite_n || !bwrite_en_n;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[g] = !gwrite_n || (!bwrite_en_n && !byte_we_n[g]);
   end
endmodule

// File: rtl/bsr_burst_ctrl.sv
module bsr_burst_ctrl
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [ADDR_W-1:0] addr,
   input  logic              proc_strobe_n,
   input  logic              ctrl_strobe_n,
   input  logic              bank_en_n,
   input  logic              advance_n,
   input  logic              order_sel,
   input  logic              write_req,
   output acc_kind_e         kind_nxt,
   output logic [ADDR_W-1:0] access_addr,
   output acc_kind_e         kind_q,
   output logic [ADDR_W-1:0] base_q,
   output logic [BURST_W-1:0] cnt_q
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [ADDR_W-1:0]  base_nxt;
   logic [BURST_W-1:0] cnt_nxt;
   logic [BURST_W-1:0] low_lin;
   logic [BURST_W-1:0] low_int;

   always_comb begin
      kind_nxt = kind_q;
      base_nxt = base_q;
      cnt_nxt  = cnt_q;
      if (!proc_strobe_n && !bank_en_n) begin
         kind_nxt = ACC_READ;
         base_nxt = addr;
         cnt_nxt  = '0;
      end else if (!ctrl_strobe_n) begin
         if (bank_en_n) begin
            kind_nxt = ACC_IDLE;
         end else begin
            kind_nxt = write_req ? ACC_WRITE : ACC_READ;
            base_nxt = addr;
            cnt_nxt  = '0;
         end
      end else if (kind_q != ACC_IDLE && !advance_n) begin
         cnt_nxt = cnt_q + BURST_W'(1);
      end
   end

   assign low_lin = base_nxt[BURST_W-1:0] + cnt_nxt;

   for (genvar b = 0; b < BURST_W; b++) begin : g_xor
      assign low_int[b] = base_nxt[b] ^ cnt_nxt[b];
   end

   assign access_addr = {base_nxt[ADDR_W-1 -: HI_W], order_sel ? low_int : low_lin};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= ACC_IDLE;
         base_q <= '0;
         cnt_q  <= '0;
      end else if (!hold) begin
         kind_q <= kind_nxt;
         base_q <= base_nxt;
         cnt_q  <= cnt_nxt;
      end
   end
endmodule

// File: rtl/bsr_storage.sv
module bsr_storage #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 8,
   parameter int SLOT_W = 9
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [LANES-1:0]         wr_mask,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES*SLOT_W-1:0]  wr_word,
   output logic [LANES*SLOT_W-1:0]  rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SLOT_W-1:0] cells [DEPTH];
      logic [SLOT_W-1:0] rd_lane;

      always_ff @(posedge clk) begin
         if (wr_en && wr_mask[g]) cells[addr] <= wr_word[g*SLOT_W +: SLOT_W];
         if (rd_en)               rd_lane     <= cells[addr];
      end

      assign rd_word[g*SLOT_W +: SLOT_W] = rd_lane;
   end
endmodule

// File: rtl/burst_parity_sram.sv
module burst_parity_sram
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 8,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     proc_strobe_n,
   input  logic                     ctrl_strobe_n,
   input  logic                     bank_en_n,
   input  logic                     advance_n,
   input  logic                     order_sel,
   input  logic                     gwrite_n,
   input  logic                     bwrite_en_n,
   input  logic [LANES-1:0]         byte_we_n,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic [LANES-1:0]         wpar,
   input  logic                     out_en_n,
   input  logic                     snooze,
   output logic [LANES*LANE_W-1:0]  rdata,
   output logic [LANES-1:0]         rpar,
   output logic                     q_drive
);
   localparam int SLOT_W = LANE_W + 1;
   localparam int WORD_W = LANES * SLOT_W;

   if (ADDR_W <= BURST_W) begin : g_bad_addr
      $error("ADDR_W must exceed BURST_W");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end

   logic               write_req;
   logic [LANES-1:0]   lane_mask;
   acc_kind_e          kind_nxt;
   acc_kind_e          burst_kind_q;
   logic [ADDR_W-1:0]  access_addr;
   logic [ADDR_W-1:0]  burst_base;
   logic [BURST_W-1:0] burst_cnt;
   logic [WORD_W-1:0]  wr_word;
   logic [WORD_W-1:0]  rd_word;
   logic               acc_go;
   logic               rd_valid_q;

   bsr_lane_mask #(.LANES(LANES)) u_mask (
      .gwrite_n    (gwrite_n),
      .bwrite_en_n (bwrite_en_n),
      .byte_we_n   (byte_we_n),
      .write_req   (write_req),
      .lane_mask   (lane_mask)
   );

   bsr_burst_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .hold          (snooze),
      .addr          (addr),
      .proc_strobe_n (proc_strobe_n),
      .ctrl_strobe_n (ctrl_strobe_n),
      .bank_en_n     (bank_en_n),
      .advance_n     (advance_n),
      .order_sel     (order_sel),
      .write_req     (write_req),
      .kind_nxt      (kind_nxt),
      .access_addr   (access_addr),
      .kind_q        (burst_kind_q),
      .base_q        (burst_base),
      .cnt_q         (burst_cnt)
   );

   assign acc_go = !snooze && (kind_nxt != ACC_IDLE);

   for (genvar g = 0; g < LANES; g++) begin : g_pack
      assign wr_word[g*SLOT_W +: SLOT_W] = {wpar[g], wdata[g*LANE_W +: LANE_W]};
      assign rdata[g*LANE_W +: LANE_W]   = q_drive ? rd_word[g*SLOT_W +: LANE_W] : '0;
      assign rpar[g]                     = q_drive & rd_word[g*SLOT_W + LANE_W];
   end

   bsr_storage #(.ADDR_W(ADDR_W), .LANES(LANES), .SLOT_W(SLOT_W)) u_store (
      .clk     (clk),
      .wr_en   (acc_go && kind_nxt == ACC_WRITE),
      .wr_mask (lane_mask),
      .rd_en   (acc_go && kind_nxt == ACC_READ),
      .addr    (access_addr),
      .wr_word (wr_word),
      .rd_word (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      rd_valid_q <= 1'b0;
      else if (snooze) rd_valid_q <= 1'b0;
      else             rd_valid_q <= (kind_nxt == ACC_READ);
   end

   assign q_drive = rd_valid_q && !out_en_n && !snooze;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker
   import burst_sram_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 8,
   parameter int LANE_W  = 8,
   parameter int BURST_W = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    proc_strobe_n,
   input logic                    ctrl_strobe_n,
   input logic                    bank_en_n,
   input logic                    advance_n,
   input logic                    out_en_n,
   input logic                    snooze,
   input logic [LANES*LANE_W-1:0] rdata,
   input logic [LANES-1:0]        rpar,
   input logic                    q_drive,
   input acc_kind_e               burst_kind_q,
   input logic [ADDR_W-1:0]       burst_base,
   input logic [BURST_W-1:0]      burst_cnt
);
   logic no_start;
   assign no_start = (proc_strobe_n || bank_en_n) && ctrl_strobe_n;

   AST_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_en_n || snooze) |-> (!q_drive && rdata == '0 && rpar == '0)); // R11

   AST_PROC_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && !bank_en_n && !snooze) |=> (out_en_n || snooze || q_drive)); // R2

   AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ((proc_strobe_n || bank_en_n) && !ctrl_strobe_n && bank_en_n && !snooze) |=> !q_drive); // R4

   AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_kind_q != ACC_IDLE && no_start && !advance_n && !snooze)
      |=> (burst_cnt == BURST_W'($past(burst_cnt) + BURST_W'(1)) && $stable(burst_base))); // R5

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (no_start && advance_n && !snooze) |=> ($stable(burst_cnt) && $stable(burst_base))); // R6

   AST_SNOOZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      snooze |=> ($stable(burst_cnt) && $stable(burst_base) && $stable(burst_kind_q))); // R12
endmodule

bind burst_parity_sram bsr_checker #(
   .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .BURST_W(BURST_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .proc_strobe_n (proc_strobe_n),
   .ctrl_strobe_n (ctrl_strobe_n),
   .bank_en_n     (bank_en_n),
   .advance_n     (advance_n),
   .out_en_n      (out_en_n),
   .snooze        (snooze),
   .rdata         (rdata),
   .rpar          (rpar),
   .q_drive       (q_drive),
   .burst_kind_q  (burst_kind_q),
   .burst_base    (burst_base),
   .burst_cnt     (burst_cnt)
);

// File: tb/tb_burst_parity_sram.sv
module tb_burst_parity_sram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic        ps_n = 1'b1, cs_n = 1'b1, ben_n = 1'b1, adv_n = 1'b1, ord = 1'b0;
   logic        gw_n = 1'b1, bwe_n = 1'b1;
   logic [7:0]  bw_n = 8'hFF;
   logic [63:0] wd = '0;
   logic [7:0]  wp = '0;
   logic        oe_n = 1'b0, zz = 1'b0;
   logic [63:0] rdata;
   logic [7:0]  rpar;
   logic        q_drive;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] ref_d [64];
   logic [7:0]  ref_p [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_parity_sram dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(ps_n), .ctrl_strobe_n(cs_n),
      .bank_en_n(ben_n), .advance_n(adv_n), .order_sel(ord), .gwrite_n(gw_n),
      .bwrite_en_n(bwe_n), .byte_we_n(bw_n), .wdata(wd), .wpar(wp), .out_en_n(oe_n),
      .snooze(zz), .rdata(rdata), .rpar(rpar), .q_drive(q_drive)
   );

   function automatic logic [63:0] pat_d(input int a, input int s);
      return {8'(a), 8'(s), 8'(a ^ s), 8'(a + s), 16'hC3A5 ^ 16'(s * 97), 16'(a * 131 + s)};
   endfunction
   function automatic logic [7:0] pat_p(input int a, input int s);
      return 8'((a * 3) ^ (s * 5) ^ 8'h5A);
   endfunction

   task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_word(input string req, input int a);
      check({req, " drive"}, 72'(q_drive), 72'd1);
      check({req, " word"}, {rpar, rdata}, {ref_p[a], ref_d[a]});
   endtask

   task automatic set_idle();
      ps_n = 1'b1; cs_n = 1'b1; ben_n = 1'b1; adv_n = 1'b1;
      gw_n = 1'b1; bwe_n = 1'b1; bw_n = 8'hFF; oe_n = 1'b0; zz = 1'b0;
   endtask

   // whole-word write through the controller strobe; per-lane inputs set to "no write"
   task automatic wr_global(input int a, input int s);
      cs_n = 1'b0; ben_n = 1'b0; addr = AW'(a); gw_n = 1'b0; bwe_n = 1'b1; bw_n = 8'hFF;
      wd = pat_d(a, s); wp = pat_p(a, s);
      @(negedge clk);
      set_idle();
      ref_d[a] = pat_d(a, s); ref_p[a] = pat_p(a, s);
   endtask

   task automatic rd_start(input int a);
      ps_n = 1'b0; ben_n = 1'b0; addr = AW'(a);
      @(negedge clk);
      set_idle();
   endtask

   task automatic t_reset();
      check("R1 drive", 72'(q_drive), 72'd0);
      check("R1 word", {rpar, rdata}, 72'd0);
   endtask

   task automatic t_proc_read();
      wr_global(5, 1);
      ps_n = 1'b0; ben_n = 1'b0; addr = AW'(5); gw_n = 1'b0; bwe_n = 1'b0; bw_n = 8'h00;
      wd = pat_d(5, 99); wp = pat_p(5, 99);
      @(negedge clk);
      set_idle();
      chk_word("R2 read despite write inputs", 5);
      rd_start(5);
      chk_word("R2 no write happened", 5);
   endtask

   task automatic t_ctrl_ops();
      cs_n = 1'b0; ben_n = 1'b0; addr = AW'(6); gw_n = 1'b1; bwe_n = 1'b0; bw_n = 8'h00;
      wd = pat_d(6, 3); wp = pat_p(6, 3);
      @(negedge clk);
      set_idle();
      ref_d[6] = pat_d(6, 3); ref_p[6] = pat_p(6, 3);
      cs_n = 1'b0; ben_n = 1'b0; addr = AW'(6); wd = pat_d(6, 77); wp = pat_p(6, 77);
      @(negedge clk);
      set_idle();
      chk_word("R3 ctrl read of ctrl write", 6);
   endtask

   task automatic t_byte_write();
      logic [7:0] mask_n;
      mask_n = 8'hA5;
      wr_global(7, 10);
      chk_word_after_read(7, "R9 gw ignores lane inputs");
      cs_n = 1'b0; ben_n = 1'b0; addr = AW'(7); gw_n = 1'b1; bwe_n = 1'b0; bw_n = mask_n;
      wd = pat_d(7, 11); wp = pat_p(7, 11);
      @(negedge clk);
      set_idle();
      for (int i = 0; i < 8; i++) begin
         if (!mask_n[i]) begin
            ref_d[7][i*8 +: 8] = pat_d(7, 11) >> (i * 8);
            ref_p[7][i] = pat_p(7, 11) >> i;
         end
      end
      chk_word_after_read(7, "R10 per-lane write");
   endtask

   task automatic chk_word_after_read(input int a, input string req);
      rd_start(a);
      chk_word(req, a);
   endtask

   task automatic t_bursts();
      for (int a = 16; a < 20; a++) wr_global(a, a + 20);
      ord = 1'b0;
      rd_start(17);
      chk_word("R7 linear beat0", 17);
      adv_n = 1'b0; @(negedge clk); chk_word("R7 R5 linear beat1", 18);
      @(negedge clk); chk_word("R7 R5 linear beat2", 19);
      @(negedge clk); chk_word("R7 R5 linear wrap", 16);
      adv_n = 1'b1; @(negedge clk); chk_word("R6 wait holds", 16);
      ord = 1'b1;
      rd_start(17);
      chk_word("R8 interleaved beat0", 17);
      adv_n = 1'b0; @(negedge clk); chk_word("R8 interleaved beat1", 16);
      @(negedge clk); chk_word("R8 interleaved beat2", 19);
      @(negedge clk); chk_word("R8 interleaved beat3", 18);
      set_idle();
      ord = 1'b0;
   endtask

   task automatic t_write_burst();
      ord = 1'b1;
      cs_n = 1'b0; ben_n = 1'b0; addr = AW'(33); gw_n = 1'b0;
      wd = pat_d(33, 40); wp = pat_p(33, 40);
      @(negedge clk);
      ref_d[33] = pat_d(33, 40); ref_p[33] = pat_p(33, 40);
      cs_n = 1'b1; ben_n = 1'b1; adv_n = 1'b0;
      wd = pat_d(32, 41); wp = pat_p(32, 41);
      @(negedge clk);
      ref_d[32] = pat_d(32, 41); ref_p[32] = pat_p(32, 41);
      adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b0; bw_n = 8'hFE;
      wd = pat_d(32, 42); wp = pat_p(32, 42);
      @(negedge clk);
      ref_d[32][7:0] = pat_d(32, 42) & 64'hFF; ref_p[32][0] = pat_p(32, 42) & 8'h01;
      set_idle();
      ord = 1'b0;
      chk_word_after_read(33, "R13 write burst first beat");
      chk_word_after_read(32, "R13 write burst advance then wait lane mask");
   endtask

   task automatic t_oe();
      rd_start(18);
      chk_word("R11 baseline", 18);
      oe_n = 1'b1; #1;
      check("R11 oe high drive", 72'(q_drive), 72'd0);
      check("R11 oe high word", {rpar, rdata}, 72'd0);
      oe_n = 1'b0; #1;
      chk_word("R11 oe restored", 18);
   endtask

   task automatic t_deselect();
      rd_start(16);
      cs_n = 1'b0; ben_n = 1'b1;
      @(negedge clk);
      set_idle();
      check("R4 deselect drive", 72'(q_drive), 72'd0);
      adv_n = 1'b0;
      @(negedge clk);
      check("R4 advance after deselect", 72'(q_drive), 72'd0);
      set_idle();
      ps_n = 1'b0; cs_n = 1'b0; ben_n = 1'b0; gw_n = 1'b0; addr = AW'(17);
      wd = pat_d(17, 88); wp = pat_p(17, 88);
      @(negedge clk);
      set_idle();
      chk_word("R2 processor start wins", 17);
   endtask

   task automatic t_snooze();
      rd_start(19);
      chk_word("R12 baseline", 19);
      zz = 1'b1; cs_n = 1'b0; ben_n = 1'b0; gw_n = 1'b0; addr = AW'(19);
      wd = pat_d(19, 55); wp = pat_p(19, 55);
      @(negedge clk);
      check("R12 snooze drive", 72'(q_drive), 72'd0);
      check("R12 snooze word", {rpar, rdata}, 72'd0);
      set_idle();
      @(negedge clk);
      chk_word("R12 burst kept, wait reread", 19);
      chk_word_after_read(19, "R12 contents kept");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      set_idle();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_proc_read();
      t_ctrl_ops();
      t_byte_write();
      t_bursts();
      t_write_burst();
      t_oe();
      t_deselect();
      t_snooze();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule